// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block sits in the read path of a parallel NOR flash model. While the internal program/erase engine is working, a bus read does not return array contents. It returns a status byte instead. That byte carries a polling bit derived from the data being written, two toggle bits that advance on reads, and error/indication flags. When no operation is running, reads pass the array data straight through.

The command decoder, the cell array and the programming physics are outside this block. Their effects arrive as level inputs (`busy_prog`, `busy_erase`, `erase_susp`), a pulse that reports an attempt on a protected block (`prot_start`, with `prot_erase` giving its kind), and a sticky timeout input. A protected-block attempt is aborted silently: the block reports status for a fixed number of clock cycles, then returns to array reads. That count is derived from `CLK_MHZ` and the abort durations in microseconds.

A read is recognised on the rising edge of `rd_strobe`, sampled by `clk`. The returned byte appears on `dout` from the cycle after that edge and is held until the next read.

Top module: `flash_status_rpt`

## Requirements
- R1: With no operation and no abort active, a read returns `array_data` (sampled at the strobe edge) on `dout` one cycle later, with `stat_out` low. The same applies after an operation completes. Reset leaves `dout` at 0 and `stat_out` at 0.
- R2: A status byte has the layout bit7 poll, bit6 read toggle, bit5 timeout flag, bit3 erase flag, bit2 block toggle. Bits 4, 1 and 0 are reserved and read as `RSVD_FILL` (default 0). `stat_out` is high whenever `dout` holds a status byte.
- R3: While a program is reported, bit7 is the inverse of `prog_dq7` and bit3 is 0.
- R4: While an unsuspended erase is reported, bit7 is 0 and bit3 is 1.
- R5: While an erase is suspended, a read with `rd_block == tgt_block` returns status with bit7 = 1 and bit3 = 1, and does not advance bit6. A read of any other block returns array data.
- R6: Bit6 reads 0 on the first status read after an operation starts. It inverts after each later status read at any address. A strobe held high counts as one read.
- R7: Bit2 inverts only on reads with `rd_block == tgt_block` while an erase is running or suspended. It reads 0 on the first such read after an operation starts, and other reads leave it unchanged.
- R8: After `prot_start` with `prot_erase = 1`, status is returned for reads whose strobe edge falls within `CLK_MHZ*ERASE_ABORT_US` cycles after the pulse. Bit7 = 0, bit3 = 1 and bit5 is not set by the abort. Later reads return array data.
- R9: After `prot_start` with `prot_erase = 0`, status is returned for `CLK_MHZ*PROG_ABORT_US` cycles, with bit7 equal to the inverse of `prog_dq7` and bit3 = 0. Afterwards reads return array data.
- R10: A `timeout_err` pulse sets bit5 in every later status byte until reset, across operations.
- R11: The reported source has a fixed priority: an abort first, then a program, then an erase. A program started during a suspended erase resets both toggles.
- R12: An operation start and a read strobe edge in the same cycle return bit6 = 0, and the next status read returns bit6 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_prog | input | 1 | Program in progress |
| busy_erase | input | 1 | Erase in progress (also high while suspended) |
| erase_susp | input | 1 | Erase suspension has taken effect |
| prot_start | input | 1 | Single-cycle pulse: attempt on a protected block |
| prot_erase | input | 1 | Kind of the protected attempt: 1 erase, 0 program |
| prog_dq7 | input | 1 | Data bit being programmed at bit position 7 |
| tgt_block | input | BW | Block being erased |
| rd_block | input | BW | Block of the current read address |
| rd_strobe | input | 1 | Bus read strobe, rising edge starts a read |
| array_data | input | 8 | Array contents at the read address |
| timeout_err | input | 1 | Engine timeout indication |
| dout | output | 8 | Read data or status byte |
| stat_out | output | 1 | `dout` holds a status byte |

## Verification
The two functions that meet in one cycle are the clearing of the toggle at an operation start and the advance of that same toggle by a read. The bench raises `busy_prog` and the read strobe on the same falling edge, so both are sampled by one rising edge. It then expects bit6 = 0 on that read and bit6 = 1 on the read after it. The abort windows are probed with one read on the last cycle inside the window and one read on the first cycle after it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [2:0] {
      REP_ARRAY,
      REP_ABT_ERASE,
      REP_ABT_PROG,
      REP_PROG,
      REP_ERASE,
      REP_SUSP
   } rep_e;

   localparam logic [7:0] RSVD_MASK = 8'b0001_0011;
endpackage

// File: rtl/fsr_toggle.sv
module fsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic cur
);
   logic q;

   assign cur = clr ? 1'b0 : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (clr || adv)
         q <= adv ? ~cur : 1'b0;
   end
endmodule

// File: rtl/fsr_abort_timer.sv
module fsr_abort_timer #(
   parameter int ERASE_CYC = 12500,
   parameter int PROG_CYC  = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic kind_erase,
   output logic active,
   output logic erase_q
);
   localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] E_LOAD = CW'(ERASE_CYC);
   localparam logic [CW-1:0] P_LOAD = CW'(PROG_CYC);

   logic [CW-1:0] cnt;

   assign active = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         erase_q <= 1'b0;
      end else if (start) begin
         cnt     <= kind_erase ? E_LOAD : P_LOAD;
         erase_q <= kind_erase;
      end else if (active) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/fsr_classify.sv
module fsr_classify
   import fsr_pkg::*;
(
   input  logic abort_now,
   input  logic abort_erase,
   input  logic busy_prog,
   input  logic busy_erase,
   input  logic erase_susp,
   input  logic in_blk,
   output rep_e rep
);
   always_comb begin
      if (abort_now)
         rep = abort_erase ? REP_ABT_ERASE : REP_ABT_PROG;
      else if (busy_prog)
         rep = REP_PROG;
      else if (busy_erase && !erase_susp)
         rep = REP_ERASE;
      else if (busy_erase && in_blk)
         rep = REP_SUSP;
      else
         rep = REP_ARRAY;
   end
endmodule

// File: rtl/fsr_compose.sv
module fsr_compose
   import fsr_pkg::*;
#(
   parameter bit RSVD_FILL = 1'b0
) (
   input  rep_e       rep,
   input  logic       prog_dq7,
   input  logic       tog6,
   input  logic       tog2,
   input  logic       err,
   output logic [7:0] sbyte
);
   logic       poll, eflag;
   logic [7:0] live;

   always_comb begin
      unique case (rep)
         REP_ABT_ERASE, REP_ERASE: begin poll = 1'b0;      eflag = 1'b1; end
         REP_SUSP:                 begin poll = 1'b1;      eflag = 1'b1; end
         REP_ABT_PROG, REP_PROG:   begin poll = ~prog_dq7; eflag = 1'b0; end
         default:                  begin poll = 1'b0;      eflag = 1'b0; end
      endcase
      live  = {poll, tog6, err, 1'b0, eflag, tog2, 2'b00};
      sbyte = (live & ~RSVD_MASK) | (RSVD_FILL ? RSVD_MASK : 8'h00);
   end
endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
   import fsr_pkg::*;
#(
   parameter int BW             = 4,
   parameter int CLK_MHZ        = 125,
   parameter int ERASE_ABORT_US = 100,
   parameter int PROG_ABORT_US  = 1,
   parameter bit RSVD_FILL      = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_prog,
   input  logic          busy_erase,
   input  logic          erase_susp,
   input  logic          prot_start,
   input  logic          prot_erase,
   input  logic          prog_dq7,
   input  logic [BW-1:0] tgt_block,
   input  logic [BW-1:0] rd_block,
   input  logic          rd_strobe,
   input  logic [7:0]    array_data,
   input  logic          timeout_err,
   output logic [7:0]    dout,
   output logic          stat_out
);
   localparam int ERASE_CYC = CLK_MHZ * ERASE_ABORT_US;
   localparam int PROG_CYC  = CLK_MHZ * PROG_ABORT_US;

   generate
      if (BW < 1) begin : g_bad_bw
         $error("BW must be at least 1");
      end
      if (CLK_MHZ < 1 || ERASE_ABORT_US < 1 || PROG_ABORT_US < 1) begin : g_bad_time
         $error("clock and abort durations must be positive");
      end
   endgenerate

   logic rd_q, bp_q, be_q, err_q;
   logic rd_rise, op_start, in_blk;
   logic ab_act, ab_erase_q, abort_now, abort_erase;
   logic tog6, tog2, adv6, adv2, is_stat;
   logic [7:0] sbyte;
   rep_e rep;

   assign rd_rise     = rd_strobe & ~rd_q;
   assign op_start    = (busy_prog & ~bp_q) | (busy_erase & ~be_q) | prot_start;
   assign in_blk      = (rd_block == tgt_block);
   assign abort_now   = ab_act | prot_start;
   assign abort_erase = prot_start ? prot_erase : ab_erase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         bp_q  <= 1'b0;
         be_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         rd_q <= rd_strobe;
         bp_q <= busy_prog;
         be_q <= busy_erase;
         if (timeout_err) err_q <= 1'b1;
      end
   end

   fsr_abort_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(prot_start), .kind_erase(prot_erase),
      .active(ab_act), .erase_q(ab_erase_q)
   );

   fsr_classify u_cls (
      .abort_now(abort_now), .abort_erase(abort_erase), .busy_prog(busy_prog),
      .busy_erase(busy_erase), .erase_susp(erase_susp), .in_blk(in_blk), .rep(rep)
   );

   assign is_stat = (rep != REP_ARRAY);
   assign adv6    = rd_rise & is_stat & (rep != REP_SUSP);
   assign adv2    = rd_rise & in_blk & ((rep == REP_ERASE) || (rep == REP_SUSP));

   fsr_toggle u_tog_rd (
      .clk(clk), .rst_n(rst_n), .clr(op_start), .adv(adv6), .cur(tog6)
   );

   fsr_toggle u_tog_blk (
      .clk(clk), .rst_n(rst_n), .clr(op_start), .adv(adv2), .cur(tog2)
   );

   fsr_compose #(.RSVD_FILL(RSVD_FILL)) u_cmp (
      .rep(rep), .prog_dq7(prog_dq7), .tog6(tog6), .tog2(tog2), .err(err_q), .sbyte(sbyte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= 8'h00;
         stat_out <= 1'b0;
      end else if (rd_rise) begin
         dout     <= is_stat ? sbyte : array_data;
         stat_out <= is_stat;
      end
   end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
   parameter int BW        = 4,
   parameter bit RSVD_FILL = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_rise,
   input logic          busy_prog,
   input logic          busy_erase,
   input logic          erase_susp,
   input logic          abort_now,
   input logic          prog_dq7,
   input logic [BW-1:0] tgt_block,
   input logic [BW-1:0] rd_block,
   input logic [7:0]    array_data,
   input logic          timeout_err,
   input logic          err_q,
   input logic [7:0]    dout,
   input logic          stat_out
);
   p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && !busy_prog && !busy_erase && !abort_now)
      |=> (dout == $past(array_data) && !stat_out));

   p_rsvd_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_out |-> (dout[4] == RSVD_FILL && dout[1:0] == {2{RSVD_FILL}}));

   p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && busy_prog && !abort_now)
      |=> (stat_out && dout[7] == !$past(prog_dq7) && !dout[3]));

   p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && busy_erase && !erase_susp && !busy_prog && !abort_now)
      |=> (stat_out && !dout[7] && dout[3]));

   p_susp_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && busy_erase && erase_susp && !busy_prog && !abort_now
       && rd_block != tgt_block) |=> !stat_out);

   p_susp_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && busy_erase && erase_susp && !busy_prog && !abort_now
       && rd_block == tgt_block) |=> (stat_out && dout[7]));

   p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |=> err_q);

   p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

bind flash_status_rpt fsr_checker #(.BW(BW), .RSVD_FILL(RSVD_FILL)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_rise(rd_rise), .busy_prog(busy_prog),
   .busy_erase(busy_erase), .erase_susp(erase_susp), .abort_now(abort_now),
   .prog_dq7(prog_dq7), .tgt_block(tgt_block), .rd_block(rd_block),
   .array_data(array_data), .timeout_err(timeout_err), .err_q(err_q),
   .dout(dout), .stat_out(stat_out)
);

// File: tb/flash_status_rpt_bench.sv
`timescale 1ns/1ps
module flash_status_rpt_bench;
   localparam int BW    = 4;
   localparam int E_CYC = 125 * 100;
   localparam int P_CYC = 125 * 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          busy_prog = 1'b0, busy_erase = 1'b0, erase_susp = 1'b0;
   logic          prot_start = 1'b0, prot_erase = 1'b0, prog_dq7 = 1'b0;
   logic [BW-1:0] tgt_block = '0, rd_block = '0;
   logic          rd_strobe = 1'b0, timeout_err = 1'b0;
   logic [7:0]    array_data = 8'h00;
   logic [7:0]    dout;
   logic          stat_out;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;
   logic m_t6 = 1'b0, m_t2 = 1'b0, m_err = 1'b0, m_abort = 1'b0, m_ab_erase = 1'b0;

   always #4 clk = ~clk;

   flash_status_rpt #(.BW(BW)) u_flash_status_rpt (
      .clk(clk), .rst_n(rst_n), .busy_prog(busy_prog), .busy_erase(busy_erase),
      .erase_susp(erase_susp), .prot_start(prot_start), .prot_erase(prot_erase),
      .prog_dq7(prog_dq7), .tgt_block(tgt_block), .rd_block(rd_block),
      .rd_strobe(rd_strobe), .array_data(array_data), .timeout_err(timeout_err),
      .dout(dout), .stat_out(stat_out)
   );

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual stat/dout=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] sbyte(input logic d7, input logic d3);
      return {d7, m_t6, m_err, 1'b0, d3, m_t2, 2'b00};
   endfunction

   task automatic do_read(input logic [BW-1:0] blk, input logic [7:0] arr,
                          input logic start_prog, input string req);
      logic st, d7, d3, a6, a2, inb;
      logic [7:0] exp;
      @(negedge clk);
      if (start_prog) begin busy_prog = 1'b1; m_t6 = 1'b0; m_t2 = 1'b0; end
      rd_block = blk; array_data = arr; rd_strobe = 1'b1;
      inb = (blk == tgt_block);
      st = 1'b1; a6 = 1'b1; a2 = 1'b0; d7 = 1'b0; d3 = 1'b0;
      if (m_abort) begin d7 = m_ab_erase ? 1'b0 : ~prog_dq7; d3 = m_ab_erase; end
      else if (busy_prog) d7 = ~prog_dq7;
      else if (busy_erase && !erase_susp) begin d3 = 1'b1; a2 = inb; end
      else if (busy_erase && inb) begin d7 = 1'b1; d3 = 1'b1; a6 = 1'b0; a2 = 1'b1; end
      else st = 1'b0;
      exp = st ? sbyte(d7, d3) : arr;
      if (st && a6) m_t6 = ~m_t6;
      if (st && a2) m_t2 = ~m_t2;
      @(negedge clk);
      check(req, {stat_out, dout}, {st, exp});
      rd_strobe = 1'b0;
   endtask

   task automatic start_op(input bit is_prog);
      @(negedge clk);
      if (is_prog) busy_prog = 1'b1; else busy_erase = 1'b1;
      m_t6 = 1'b0; m_t2 = 1'b0;
   endtask

   task automatic run_abort(input logic er, input int n_cyc, input int m,
                            input logic in_window, input string req);
      @(negedge clk);
      prot_erase = er; prot_start = 1'b1; m_t6 = 1'b0; m_t2 = 1'b0;
      @(negedge clk);
      prot_start = 1'b0;
      repeat (m) @(negedge clk);
      m_abort = in_window; m_ab_erase = er;
      do_read(BW'($urandom), 8'($urandom), 1'b0, req);
      m_abort = 1'b0;
      repeat (n_cyc) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5171));
      repeat (3) @(negedge clk);
      check("R1 reset", {stat_out, dout}, 9'h000);
      rst_n = 1'b1;

      for (int i = 0; i < 4; i++) do_read(BW'($urandom), 8'($urandom), 1'b0, "R1 idle");

      // R3 R6 R7 R2: program with random data bit and addresses
      start_op(1'b1);
      for (int i = 0; i < 8; i++) begin
         prog_dq7 = 1'($urandom);
         do_read(BW'($urandom), 8'($urandom), 1'b0, "R3 R6 R7 program");
      end
      @(negedge clk) busy_prog = 1'b0;
      prog_dq7 = 1'b1;
      do_read(4'd3, 8'h80, 1'b0, "R1 after program");

      // R4 R6 R7: erase, reads in and out of the target block
      tgt_block = 4'd5;
      start_op(1'b0);
      for (int i = 0; i < 8; i++)
         do_read((i % 2 == 0) ? 4'd5 : BW'($urandom), 8'($urandom), 1'b0, "R4 R6 R7 erase");

      // R5: suspension
      @(negedge clk) erase_susp = 1'b1;
      do_read(4'd5, 8'h3C, 1'b0, "R5 suspend inside");
      do_read(4'd9, 8'hA7, 1'b0, "R5 suspend outside");
      do_read(4'd5, 8'h11, 1'b0, "R5 suspend inside again");

      // R11: program during suspend takes priority and restarts toggles
      start_op(1'b1);
      for (int i = 0; i < 3; i++) begin
         prog_dq7 = 1'($urandom);
         do_read(4'd5, 8'($urandom), 1'b0, "R11 program over erase");
      end
      @(negedge clk) busy_prog = 1'b0;
      @(negedge clk) erase_susp = 1'b0;
      do_read(4'd5, 8'h44, 1'b0, "R4 resumed erase");

      // R10: timeout flag sticky across operations
      @(negedge clk) timeout_err = 1'b1;
      @(negedge clk) timeout_err = 1'b0;
      m_err = 1'b1;
      do_read(4'd5, 8'h55, 1'b0, "R10 timeout shown");
      @(negedge clk) busy_erase = 1'b0;
      do_read(4'd2, 8'h66, 1'b0, "R1 after erase");
      start_op(1'b0);
      do_read(4'd5, 8'h77, 1'b0, "R10 held in new erase");
      @(negedge clk) busy_erase = 1'b0;

      // R12: start and read in the same cycle
      prog_dq7 = 1'b0;
      do_read(4'd1, 8'h12, 1'b1, "R12 start with read");
      do_read(4'd1, 8'h12, 1'b0, "R12 next read");
      @(negedge clk) busy_prog = 1'b0;

      // R8 R9: protected aborts, last cycle inside and first cycle past
      run_abort(1'b1, E_CYC, E_CYC - 2, 1'b1, "R8 erase abort inside");
      run_abort(1'b1, E_CYC, E_CYC - 1, 1'b0, "R8 erase abort expired");
      prog_dq7 = 1'b1;
      run_abort(1'b0, P_CYC, P_CYC - 2, 1'b1, "R9 program abort inside");
      run_abort(1'b0, P_CYC, P_CYC - 1, 1'b0, "R9 program abort expired");
      run_abort(1'b0, P_CYC, 0, 1'b1, "R9 program abort early");

      // R10: reset clears the flag
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      m_err = 1'b0;
      start_op(1'b1);
      do_read(4'd0, 8'h00, 1'b0, "R10 cleared by reset");
      @(negedge clk) busy_prog = 1'b0;

      finish_run();
   end
endmodule